// File: doc/BRIEF.md
# Serial Port Status-Change Register

This block holds the status word of one serial port channel. It gathers event strobes and level signals from the receive and transmit datapaths and presents them as a single 32-bit word on a simple register bus with address, write enable, write data and read data. Reads return the word when the address matches the register's own address and zero otherwise. Reads have no side effects.

Two flags are sticky. The overrun flag and the latched break flag stay set until software writes a zero into their bit position. Writing a one leaves them as they are. If an event and a clearing write arrive in the same cycle, the event wins. The receive-break status bit clears itself when the next non-break frame arrives. The CTS bit follows a synchronized copy of the pin. The two transmit bits follow the FIFO free-slot count and the shift-register-empty level.

Top module: `sc_status_reg`

## Requirements
- R1: Bit 5 (overrun) reads 1 in the same cycle that `evt_overrun` is high, and it stays 1 on later cycles.
- R2: A register write that hits the register address with 0 in bit 5 or in bit 0 clears that flag. A 1 in that bit leaves the flag unchanged. When a set event coincides with the clearing write, the flag reads 1 afterwards.
- R3: Bit 4 shows the `cts_pin` level (1 high, 0 low) through a two-stage synchronizer. A pin change is visible after the second rising clock edge and not after the first.
- R4: Bit 3 (receive break) reads 1 after a cycle with `evt_break_rx` high. It reads 0 after a cycle with `evt_frame_rx` high and `evt_break_rx` low. When both strobes are high in the same cycle, it reads 1.
- R5: Bit 2 (transmit ready) reads 1 one cycle after `tx_free_slots` is nonzero, and 0 one cycle after it is zero.
- R6: Bit 1 (all sent) reads 1 one cycle after `tx_free_slots` equals TX_DEPTH while `tx_shift_empty` is high, and 0 one cycle after any other combination.
- R7: Bit 0 (latched break) sets on `evt_break_rx` and stays 1 through later non-break frames until a clearing write.
- R8: Bits 31:6 always read 0. Writes to bits 31:6 and to the read-only bits 4:1 have no effect. Reads at any other address return 0, and writes at any other address change nothing.
- R9: During and right after reset the word reads 0x0000_0006: transmit ready and all sent are 1, and every other bit is 0.
- R10: Reading the register any number of times, with write enable low, leaves every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register bus address |
| reg_wr_en | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data; zero when the address does not match |
| evt_overrun | input | 1 | Receive overrun strobe |
| evt_break_rx | input | 1 | Break frame received strobe |
| evt_frame_rx | input | 1 | Non-break frame received strobe |
| cts_pin | input | 1 | Asynchronous CTS pin level |
| tx_free_slots | input | CNT_W | Number of free transmit FIFO stages |
| tx_shift_empty | input | 1 | All transmit shift registers are empty |

## Verification
The hardest case to reach from the ports is a set event landing in exactly the same cycle as a clearing write. Only that collision shows whether the set-wins priority holds. The bench drives the event strobe and a write with zero in that bit position in one cycle, then reads the flag after the edge. It uses the same collision of break and non-break frame strobes to check the receive-break bit. The transmit bits are swept over every free-slot count from 0 to TX_DEPTH, each with both shift-empty levels, against an arithmetic expectation.

// File: rtl/sc_status_pkg.sv
package sc_status_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned BIT_OVR  = 5;
    localparam int unsigned BIT_CTS  = 4;
    localparam int unsigned BIT_RBRK = 3;
    localparam int unsigned BIT_TRDY = 2;
    localparam int unsigned BIT_ALLS = 1;
    localparam int unsigned BIT_LBRK = 0;
    localparam int unsigned USED_W   = 6;

    typedef struct packed {
        logic tx_ready;
        logic all_sent;
    } tx_state_t;

endpackage

// File: rtl/sc_sync.sv
module sc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = async_i;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/sc_flag.sv
module sc_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_d;
    logic flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_q) else $error("flag lost a set event"); // R2
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(flag_q)) else $error("flag moved without cause"); // R10

endmodule

// File: rtl/sc_tx_track.sv
module sc_tx_track
    import sc_status_pkg::*;
#(
    parameter int unsigned TX_DEPTH = 8,
    parameter int unsigned CNT_W    = $clog2(TX_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] free_slots_i,
    input  logic             shift_empty_i,
    output logic             tx_ready_o,
    output logic             all_sent_o
);

    localparam logic [CNT_W-1:0] FULL_FREE = CNT_W'(TX_DEPTH);

    tx_state_t st_d;
    tx_state_t st_q;

    always_comb begin
        st_d          = st_q;
        st_d.tx_ready = (free_slots_i != '0);
        st_d.all_sent = (free_slots_i == FULL_FREE) && shift_empty_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{tx_ready: 1'b1, all_sent: 1'b1};
        else        st_q <= st_d;
    end

    assign tx_ready_o = st_q.tx_ready;
    assign all_sent_o = st_q.all_sent;

    AST_TX_NO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (free_slots_i == '0) |=> !tx_ready_o) else $error("ready with full FIFO"); // R5
    AST_ALLSENT_IMPLIES_READY: assert property (@(posedge clk) disable iff (!rst_n)
        all_sent_o |-> tx_ready_o) else $error("all sent but not ready"); // R6

endmodule

// File: rtl/sc_status_reg.sv
module sc_status_reg
    import sc_status_pkg::*;
#(
    parameter int unsigned ADDR_W      = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR = 4'hC,
    parameter int unsigned TX_DEPTH    = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CNT_W       = $clog2(TX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              evt_overrun,
    input  logic              evt_break_rx,
    input  logic              evt_frame_rx,
    input  logic              cts_pin,
    input  logic [CNT_W-1:0]  tx_free_slots,
    input  logic              tx_shift_empty
);

    logic wr_hit;
    logic clr_ovr;
    logic clr_lbrk;
    logic ovr_q;
    logic rbrk_q;
    logic lbrk_q;
    logic cts_s;
    logic tx_ready;
    logic all_sent;
    logic [WORD_W-1:0] word;
    logic unused_wdata;

    assign wr_hit   = reg_wr_en && (reg_addr == REG_ADDR);
    assign clr_ovr  = wr_hit && !reg_wdata[BIT_OVR];
    assign clr_lbrk = wr_hit && !reg_wdata[BIT_LBRK];
    assign unused_wdata = ^{reg_wdata[31:6], reg_wdata[4:1]};

    sc_sync #(.STAGES(SYNC_STAGES)) i_cts_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cts_pin),
        .sync_o  (cts_s)
    );

    sc_flag i_ovr_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (evt_overrun),
        .clr_i  (clr_ovr),
        .flag_o (ovr_q)
    );

    sc_flag i_rbrk_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (evt_break_rx),
        .clr_i  (evt_frame_rx),
        .flag_o (rbrk_q)
    );

    sc_flag i_lbrk_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (evt_break_rx),
        .clr_i  (clr_lbrk),
        .flag_o (lbrk_q)
    );

    sc_tx_track #(.TX_DEPTH(TX_DEPTH), .CNT_W(CNT_W)) i_tx_track (
        .clk           (clk),
        .rst_n         (rst_n),
        .free_slots_i  (tx_free_slots),
        .shift_empty_i (tx_shift_empty),
        .tx_ready_o    (tx_ready),
        .all_sent_o    (all_sent)
    );

    always_comb begin
        word           = '0;
        word[BIT_OVR]  = ovr_q | evt_overrun;
        word[BIT_CTS]  = cts_s;
        word[BIT_RBRK] = rbrk_q;
        word[BIT_TRDY] = tx_ready;
        word[BIT_ALLS] = all_sent;
        word[BIT_LBRK] = lbrk_q;
        reg_rdata      = (reg_addr == REG_ADDR) ? word : '0;
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[31:USED_W] == '0) else $error("reserved bits nonzero"); // R8
    AST_OVR_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_overrun && reg_addr == REG_ADDR) |-> reg_rdata[BIT_OVR]) else $error("overrun not immediate"); // R1
    AST_RBRK_AUTO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_frame_rx && !evt_break_rx) |=> !rbrk_q) else $error("receive break not cleared"); // R4
    AST_LBRK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (lbrk_q && !clr_lbrk) |=> lbrk_q) else $error("latched break dropped"); // R7
    AST_OVR_W1_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && wr_hit && reg_wdata[BIT_OVR]) |=> ovr_q) else $error("write one cleared overrun"); // R2

endmodule

// File: tb/test_sc_status_reg.sv
module test_sc_status_reg;

    localparam int unsigned ADDR_W   = 4;
    localparam logic [3:0]  REG_ADDR = 4'hC;
    localparam int unsigned TX_DEPTH = 8;
    localparam int unsigned CNT_W    = $clog2(TX_DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] reg_addr = REG_ADDR;
    logic              reg_wr_en = 1'b0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              evt_overrun = 1'b0;
    logic              evt_break_rx = 1'b0;
    logic              evt_frame_rx = 1'b0;
    logic              cts_pin = 1'b0;
    logic [CNT_W-1:0]  tx_free_slots = CNT_W'(TX_DEPTH);
    logic              tx_shift_empty = 1'b1;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    sc_status_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .TX_DEPTH(TX_DEPTH)) i_sc_status_reg (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_overrun(evt_overrun),
        .evt_break_rx(evt_break_rx), .evt_frame_rx(evt_frame_rx), .cts_pin(cts_pin),
        .tx_free_slots(tx_free_slots), .tx_shift_empty(tx_shift_empty)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        reg_wr_en = 1'b1;
        reg_wdata = d;
        tick();
        reg_wr_en = 1'b0;
        reg_wdata = '0;
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick(); tick();
        chk("R9 word in reset", reg_rdata, 32'h6);
        rst_n = 1'b1;
        tick();
        chk("R9 word after reset", reg_rdata, 32'h6);

        reg_addr = 4'h0;
        #1 chk("R8 other address reads zero", reg_rdata, 32'h0);
        reg_addr = REG_ADDR;

        // R1 same-cycle visibility
        evt_overrun = 1'b1;
        #1 chk("R1 overrun same cycle", {31'b0, reg_rdata[5]}, 32'h1);
        tick();
        evt_overrun = 1'b0;
        #1 chk("R1 overrun held", {31'b0, reg_rdata[5]}, 32'h1);

        // R2 write one keeps, write zero clears
        wr(32'hFFFF_FFFF);
        chk("R2 write one keeps overrun", {31'b0, reg_rdata[5]}, 32'h1);
        chk("R8 reserved ignore writes", {6'b0, reg_rdata[31:6]}, 32'h0);
        reg_addr = 4'h3;
        wr(32'h0);
        reg_addr = REG_ADDR;
        #1 chk("R8 write at other address ignored", {31'b0, reg_rdata[5]}, 32'h1);
        wr(32'hFFFF_FFDF);
        chk("R2 write zero clears overrun", {31'b0, reg_rdata[5]}, 32'h0);
        evt_overrun = 1'b1;
        wr(32'h0);
        evt_overrun = 1'b0;
        #1 chk("R2 set wins over clear overrun", {31'b0, reg_rdata[5]}, 32'h1);
        wr(32'hFFFF_FFDF);
        chk("R2 overrun cleared again", {31'b0, reg_rdata[5]}, 32'h0);

        // R4 / R7 breaks
        evt_break_rx = 1'b1; tick(); evt_break_rx = 1'b0;
        chk("R4 R7 break sets bits 3 and 0", reg_rdata & 32'h9, 32'h9);
        evt_frame_rx = 1'b1; tick(); evt_frame_rx = 1'b0;
        chk("R4 frame clears receive break", {31'b0, reg_rdata[3]}, 32'h0);
        chk("R7 latched break survives frame", {31'b0, reg_rdata[0]}, 32'h1);
        evt_break_rx = 1'b1; evt_frame_rx = 1'b1; tick();
        evt_break_rx = 1'b0; evt_frame_rx = 1'b0;
        chk("R4 break wins over frame", {31'b0, reg_rdata[3]}, 32'h1);
        wr(32'hFFFF_FFFF);
        chk("R2 write one keeps latched break", {31'b0, reg_rdata[0]}, 32'h1);
        wr(32'h0);
        chk("R2 write zero clears latched break", {31'b0, reg_rdata[0]}, 32'h0);
        chk("R8 read-only bits unaffected by write", reg_rdata, 32'h0000_000E);
        evt_break_rx = 1'b1;
        wr(32'hFFFF_FFFE);
        evt_break_rx = 1'b0;
        #1 chk("R2 set wins over clear latched break", {31'b0, reg_rdata[0]}, 32'h1);

        // R10 repeated reads
        for (int k = 0; k < 5; k++) tick();
        chk("R10 reads have no side effect", reg_rdata, 32'h0000_000F);
        wr(32'h0);

        // R3 CTS synchronizer
        for (int lvl = 0; lvl < 4; lvl++) begin
            cts_pin = lvl[0] ^ 1'b1;
            tick();
            chk("R3 cts not after one edge", {31'b0, reg_rdata[4]}, {31'b0, ~cts_pin});
            tick();
            chk("R3 cts after two edges", {31'b0, reg_rdata[4]}, {31'b0, cts_pin});
        end

        // R5 / R6 exhaustive transmit sweep
        for (int f = 0; f <= TX_DEPTH; f++) begin
            for (int se = 0; se < 2; se++) begin
                tx_free_slots  = CNT_W'(f);
                tx_shift_empty = se[0];
                tick();
                chk("R5 transmit ready", {31'b0, reg_rdata[2]}, {31'b0, (f != 0)});
                chk("R6 all sent", {31'b0, reg_rdata[1]},
                    {31'b0, (f == TX_DEPTH) && (se == 1)});
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule